// File: doc/BRIEF.md
# Machine Status Register Write Unit

This block owns the 32-bit machine status word of a hart that runs in machine, supervisor and user modes. It has two write paths. The full-privilege path can reach every field the machine level controls. The supervisor path can change only the supervisor-visible subset. Both paths meet in one legalisation stage before the new word is stored.

Legalisation does four things. A previous-privilege value that names a mode the hart lacks is dropped. The floating-point state field is pushed to either off or dirty. The summary dirty bit is rebuilt from the state fields. Whenever the stored address-translation controls change, a one-cycle pulse goes out to the translation logic so that it can invalidate cached translations.

Two parameters choose whether supervisor and user modes exist. The stored word can be read through a full machine view and through a filtered supervisor view.

Top module: `mach_status_unit`

## Requirements
- R1: A machine write stores the write data only in SIE (bit 1), MIE (3), SPIE (5), MPIE (7), SPP (8), MPP (12:11), FS (14:13), MPRV (17), SUM (18) and MXR (19). Every other bit keeps its value. The result shows on m_rdata_o after the rising edge at which m_we_i is sampled high.
- R2: MPP write data is dropped and the old MPP is kept in three cases: the data is 2, the data is 1 and supervisor mode is disabled, or the data is 0 and user mode is disabled. The other fields of the same write are still applied.
- R3: After a write, a nonzero FS value is stored as 3. FS therefore only ever reads 0 or 3.
- R4: SD (bit 31) reads 1 exactly when FS is 3 or XS (16:15) is 3. XS is never written and reads 0.
- R5: flush_o is high for the one cycle after an edge at which the stored MXR, MPP, MPRV or SUM changed. It is low after every other edge.
- R6: A supervisor write changes only SIE, SPIE, SPP, FS, SUM and MXR. FS is still coerced as in R3. MIE, MPIE, MPP and MPRV are left untouched.
- R7: s_rdata_o shows the stored bits UIE (0), SIE (1), UPIE (4), SPIE (5), SPP (8), FS (14:13), XS (16:15), SUM (18), MXR (19) and SD (31). Every other bit reads 0.
- R8: During and after reset the word holds MPP = 3 and zero in every other bit, and flush_o is low.
- R9: When m_we_i and s_we_i are high in the same cycle, only the machine write takes effect.
- R10: In a cycle with no write, the stored word is unchanged and no flush pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_we_i | input | 1 | Machine-view write strobe |
| m_wdata_i | input | 32 | Machine-view write data |
| s_we_i | input | 1 | Supervisor-view write strobe |
| s_wdata_i | input | 32 | Supervisor-view write data |
| m_rdata_o | output | 32 | Full stored word |
| s_rdata_o | output | 32 | Supervisor-filtered word |
| flush_o | output | 1 | Translation invalidate pulse |

## Verification
A write sampled at a rising edge is visible on both read ports after that same edge. The flush pulse is registered at that edge as well, so all three results are due exactly one edge after the cycle in which the stimulus was driven.

The driver applies inputs on the falling edge and queues the expected values for that cycle. The monitor takes items off the queue 5 ns after each rising edge, so every comparison lands one register stage after its stimulus. Idle cycles are queued as well, so the queue stays aligned with the edges.

A second instance with both optional modes disabled receives the same stimulus. This exposes the mode-dependent MPP handling.

// File: rtl/mstatus_pkg.sv
package mstatus_pkg;
  localparam int XW = 32;

  localparam int B_UIE  = 0;
  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_UPIE = 4;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP  = 11;
  localparam int B_FS   = 13;
  localparam int B_XS   = 15;
  localparam int B_MPRV = 17;
  localparam int B_SUM  = 18;
  localparam int B_MXR  = 19;
  localparam int B_SD   = 31;

  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_U   = 2'd0;
  localparam priv_t PRIV_S   = 2'd1;
  localparam priv_t PRIV_RSV = 2'd2;
  localparam priv_t PRIV_M   = 2'd3;

  localparam logic [1:0] FS_OFF   = 2'd0;
  localparam logic [1:0] FS_DIRTY = 2'd3;

  localparam logic [XW-1:0] M_WMASK    = 32'h000E_79AA;
  localparam logic [XW-1:0] S_VIEW     = 32'h800D_E133;
  localparam logic [XW-1:0] FLUSH_MASK = 32'h000E_1800;
  localparam logic [XW-1:0] RST_VAL    = {{(XW-B_MPP-2){1'b0}}, PRIV_M, {B_MPP{1'b0}}};
  localparam logic [XW-1:0] LIVE_MASK  = M_WMASK | (32'h3 << B_XS) | (32'h1 << B_SD);
endpackage

// File: rtl/mstatus_mpp_gate.sv
module mstatus_mpp_gate
  import mstatus_pkg::*;
#(
  parameter bit SUP_EN = 1'b1,
  parameter bit USR_EN = 1'b1
) (
  input  priv_t req_i,
  output logic  ok_o
);
  logic [3:0] ok_vec;

  for (genvar v = 0; v < 4; v++) begin : g_mode
    if (v == int'(PRIV_M)) begin : g_m
      assign ok_vec[v] = 1'b1;
    end else if (v == int'(PRIV_S)) begin : g_s
      assign ok_vec[v] = SUP_EN;
    end else if (v == int'(PRIV_U)) begin : g_u
      assign ok_vec[v] = USR_EN;
    end else begin : g_rsv
      assign ok_vec[v] = 1'b0;
    end
  end

  assign ok_o = ok_vec[req_i];
endmodule

// File: rtl/mstatus_next.sv
module mstatus_next
  import mstatus_pkg::*;
#(
  parameter bit SUP_EN = 1'b1,
  parameter bit USR_EN = 1'b1
) (
  input  logic [XW-1:0] old_i,
  input  logic [XW-1:0] wdata_i,
  input  logic          sup_view_i,
  output logic [XW-1:0] next_o
);
  logic [XW-1:0] merged;
  logic          mpp_ok;

  // supervisor data is folded into the old word, then takes the machine path
  assign merged = sup_view_i ? ((old_i & ~S_VIEW) | (wdata_i & S_VIEW)) : wdata_i;

  mstatus_mpp_gate #(.SUP_EN(SUP_EN), .USR_EN(USR_EN)) u_mpp (
    .req_i (merged[B_MPP+:2]),
    .ok_o  (mpp_ok)
  );

  always_comb begin
    next_o = (old_i & ~M_WMASK) | (merged & M_WMASK);
    if (!mpp_ok) next_o[B_MPP+:2] = old_i[B_MPP+:2];
    if (next_o[B_FS+:2] != FS_OFF) next_o[B_FS+:2] = FS_DIRTY;
    next_o[B_SD] = (next_o[B_FS+:2] == FS_DIRTY) || (next_o[B_XS+:2] == 2'b11);
  end
endmodule

// File: rtl/mstatus_state.sv
module mstatus_state
  import mstatus_pkg::*;
#(
  parameter bit SUP_EN = 1'b1,
  parameter bit USR_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [XW-1:0] next_i,
  output logic [XW-1:0] q_o,
  output logic          flush_o
);
  logic [XW-1:0] q;
  logic          flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q       <= RST_VAL;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_en_i && (((next_i ^ q) & FLUSH_MASK) != '0);
      if (wr_en_i) q <= next_i;
    end
  end

  assign q_o     = q;
  assign flush_o = flush_q;

  p_rsv_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~LIVE_MASK) == '0);

  p_mpp_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[B_MPP+:2] != PRIV_RSV) && (SUP_EN || q[B_MPP+:2] != PRIV_S)
    && (USR_EN || q[B_MPP+:2] != PRIV_U));

  p_fs_two_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[B_FS+:2] == FS_OFF) || (q[B_FS+:2] == FS_DIRTY));

  p_sd_summary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q[B_SD] == ((q[B_FS+:2] == FS_DIRTY) || (q[B_XS+:2] == 2'b11)));

  p_flush_on_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q == (((q ^ $past(q)) & FLUSH_MASK) != '0));

  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(q) && !flush_q));
endmodule

// File: rtl/mach_status_unit.sv
module mach_status_unit
  import mstatus_pkg::*;
#(
  parameter bit SUP_EN = 1'b1,
  parameter bit USR_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          m_we_i,
  input  logic [XW-1:0] m_wdata_i,
  input  logic          s_we_i,
  input  logic [XW-1:0] s_wdata_i,
  output logic [XW-1:0] m_rdata_o,
  output logic [XW-1:0] s_rdata_o,
  output logic          flush_o
);
  logic          wr_en;
  logic          sup_sel;
  logic [XW-1:0] wdata;
  logic [XW-1:0] cur;
  logic [XW-1:0] nxt;

  // machine write has priority
  assign wr_en   = m_we_i | s_we_i;
  assign sup_sel = s_we_i & ~m_we_i;
  assign wdata   = m_we_i ? m_wdata_i : s_wdata_i;

  mstatus_next #(.SUP_EN(SUP_EN), .USR_EN(USR_EN)) u_next (
    .old_i      (cur),
    .wdata_i    (wdata),
    .sup_view_i (sup_sel),
    .next_o     (nxt)
  );

  mstatus_state #(.SUP_EN(SUP_EN), .USR_EN(USR_EN)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .next_i  (nxt),
    .q_o     (cur),
    .flush_o (flush_o)
  );

  assign m_rdata_o = cur;
  assign s_rdata_o = cur & S_VIEW;

  p_sup_view_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s_rdata_o & ~S_VIEW) == '0) && ((s_rdata_o ^ m_rdata_o) & S_VIEW) == '0);

  p_sup_keeps_mfields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_we_i && !m_we_i) |=> (m_rdata_o[B_MPP+:2] == $past(m_rdata_o[B_MPP+:2]))
      && (m_rdata_o[B_MIE] == $past(m_rdata_o[B_MIE]))
      && (m_rdata_o[B_MPRV] == $past(m_rdata_o[B_MPRV])));
endmodule

// File: tb/mach_status_unit_tb.sv
module mach_status_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m_we_i = 1'b0;
  logic [31:0] m_wdata_i = '0;
  logic        s_we_i = 1'b0;
  logic [31:0] s_wdata_i = '0;
  logic [31:0] m_rdata_a, s_rdata_a, m_rdata_b, s_rdata_b;
  logic        flush_a, flush_b;

  always #10 clk_i = ~clk_i;

  mach_status_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .m_we_i(m_we_i), .m_wdata_i(m_wdata_i),
    .s_we_i(s_we_i), .s_wdata_i(s_wdata_i), .m_rdata_o(m_rdata_a),
    .s_rdata_o(s_rdata_a), .flush_o(flush_a));

  mach_status_unit #(.SUP_EN(1'b0), .USR_EN(1'b0)) dut_nsu_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .m_we_i(m_we_i), .m_wdata_i(m_wdata_i),
    .s_we_i(s_we_i), .s_wdata_i(s_wdata_i), .m_rdata_o(m_rdata_b),
    .s_rdata_o(s_rdata_b), .flush_o(flush_b));

  typedef struct {
    logic [31:0] m_a, s_a, m_b, s_b;
    logic        f_a, f_b;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [31:0] mdl_a = 32'h0000_1800;
  logic [31:0] mdl_b = 32'h0000_1800;

  localparam logic [31:0] SV_MASK = 32'h800D_E133;

  function automatic logic [31:0] mdl_next(logic [31:0] old, logic [31:0] w,
                                           bit sup, bit sen, bit uen);
    logic [31:0] r = old;
    r[1] = w[1]; r[5] = w[5]; r[8] = w[8];
    r[14:13] = w[14:13]; r[18] = w[18]; r[19] = w[19];
    if (!sup) begin
      r[3] = w[3]; r[7] = w[7]; r[17] = w[17];
      if (w[12:11] == 2'd3 || (w[12:11] == 2'd1 && sen) || (w[12:11] == 2'd0 && uen))
        r[12:11] = w[12:11];
    end
    if (r[14:13] != 2'd0) r[14:13] = 2'd3;
    r[31] = (r[14:13] == 2'd3) || (r[16:15] == 2'd3);
    return r;
  endfunction

  function automatic bit flush_of(logic [31:0] o, logic [31:0] n);
    return ((o ^ n) & 32'h000E_1800) != 0;
  endfunction

  task automatic drive(bit mw, logic [31:0] md, bit sw, logic [31:0] sd, string tag);
    exp_t e;
    logic [31:0] na, nb;
    @(negedge clk_i);
    m_we_i = mw; m_wdata_i = md; s_we_i = sw; s_wdata_i = sd;
    na = mdl_a; nb = mdl_b;
    if (mw) begin
      na = mdl_next(mdl_a, md, 1'b0, 1'b1, 1'b1);
      nb = mdl_next(mdl_b, md, 1'b0, 1'b0, 1'b0);
    end else if (sw) begin
      na = mdl_next(mdl_a, sd, 1'b1, 1'b1, 1'b1);
      nb = mdl_next(mdl_b, sd, 1'b1, 1'b0, 1'b0);
    end
    e.f_a = flush_of(mdl_a, na);
    e.f_b = flush_of(mdl_b, nb);
    mdl_a = na; mdl_b = nb;
    e.m_a = na; e.s_a = na & SV_MASK;
    e.m_b = nb; e.s_b = nb & SV_MASK;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic cmp(logic [31:0] act, logic [31:0] exp, string what, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        cmp(m_rdata_a, e.m_a, "m_rdata full", e.tag);
        cmp(s_rdata_a, e.s_a, "s_rdata full", e.tag);
        cmp({31'd0, flush_a}, {31'd0, e.f_a}, "flush full", e.tag);
        cmp(m_rdata_b, e.m_b, "m_rdata nomodes", e.tag);
        cmp(s_rdata_b, e.s_b, "s_rdata nomodes", e.tag);
        cmp({31'd0, flush_b}, {31'd0, e.f_b}, "flush nomodes", e.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk_i);
    #2;
    cmp(m_rdata_a, 32'h0000_1800, "m_rdata in reset", "R8");
    cmp({31'd0, flush_a}, 32'd0, "flush in reset", "R8");
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(0, '0, 0, '0, "R8");
    drive(0, '0, 0, '0, "R8");
    drive(1, 32'hFFFF_FFFF, 0, '0, "R1/R3/R4/R5");
    drive(0, '0, 0, '0, "R10");
    drive(1, 32'h0000_0000, 0, '0, "R1/R2");
    drive(1, 32'h0000_3800, 0, '0, "R3");
    drive(1, 32'h0000_1000, 0, '0, "R2");
    drive(1, 32'h0000_0800, 0, '0, "R2");
    drive(1, 32'h0000_4000, 0, '0, "R3");
    drive(0, '0, 1, 32'hFFFF_FFFF, "R6/R7");
    drive(0, '0, 1, 32'h0000_0000, "R6/R7");
    drive(0, '0, 1, 32'h0000_2000, "R6/R3");
    drive(1, 32'h0000_0008, 1, 32'hFFFF_FFFF, "R9");
    drive(1, 32'h0008_1808, 0, '0, "R5");
    drive(1, 32'h0008_1808, 0, '0, "R5");
    drive(1, 32'h0008_1800, 0, '0, "R5");
    drive(0, '0, 0, '0, "R10");
    drive(1, 32'h0004_1880, 0, '0, "R1/R2");
    drive(0, '0, 0, '0, "R10");
    @(negedge clk_i);
    m_we_i = 1'b0; s_we_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #8;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule